// File: doc/BRIEF.md
# Audio codec link frame receiver

This block sits on the codec side of a 256-bit serial audio link. It samples one data line on the bit clock and uses a frame marker line to find where each frame starts. From every frame it takes the 16-bit tag slot, the command address and command data slots, and the left and right playback sample slots. It then decides whether a register command or audio samples are meant for this codec.

A static codec ID input sets the mode. When the ID is zero the block acts as the primary codec and trusts the per-slot valid flags in the tag. When the ID is nonzero it acts as a secondary codec: a command counts only if the tag's ID field names this codec, and the address and data flags are ignored. Audio sample flags apply in every mode. Results come out as single-cycle strobes. Each strobe carries its address, data or sample on buses that hold their value until the next strobe.

Top module: `codec_frame_rx`

## Requirements
- R1: A frame begins at the first sample where `sync` is 1 after a sample where it was 0. Frame bit 0 is tag bit 15. Slot 0 is 16 bits wide, and slots 1 to 12 are 20 bits each, all sent MSB first, for 256 bits per frame. `sync` staying high does not restart a frame. A new low-to-high step in the middle of a frame restarts framing at bit 0.
- R2: Primary write. Conditions: `codec_id` = 0; tag bits 15, 14 and 13 all 1; tag bits 1:0 = 00; slot 1 bit 19 = 0. Result: `wr_stb` pulses one clock after the sample of frame bit 55. `wr_addr` = slot 1 bits 18:12 and `wr_data` = slot 2 bits 19:4.
- R3: Primary read. Conditions: `codec_id` = 0; tag bits 15 and 14 both 1; tag bits 1:0 = 00; slot 1 bit 19 = 1. Tag bit 13 is not needed. Result: `rd_stb` pulses one clock after the sample of frame bit 35, with `rd_addr` = slot 1 bits 18:12.
- R4: In primary mode no command strobe occurs if any of the following holds: tag bit 15 is 0; tag bit 14 is 0; tag bit 13 is 0 for a write; tag bits 1:0 are nonzero.
- R5: Secondary mode (`codec_id` ≠ 0). A command is accepted when tag bit 15 = 1 and tag bits 1:0 equal `codec_id`. Tag bits 14 and 13 have no effect. Read and write are told apart, and timed, as in R2 and R3.
- R6: In secondary mode, a tag ID field that differs from `codec_id` gives no command strobe, even when tag bits 14 and 13 are set.
- R7: When tag bits 15 and 12 are both 1, `left_stb` pulses one clock after the sample of frame bit 75, with `left_pcm` = slot 3 bits 19:2. This holds in every mode, whatever the tag ID field.
- R8: When tag bits 15 and 11 are both 1, `right_stb` pulses one clock after the sample of frame bit 95, with `right_pcm` = slot 4 bits 19:2. This holds in every mode, whatever the tag ID field.
- R9: Every strobe is high for exactly one clock. Each output bus keeps its value between its own strobes. Reset drives every output to 0.
- R10: Data sampled before any frame start, or after bit 255 of a frame until the next start, produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling and output updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker; a rising step marks frame bit 0 |
| sdata | input | 1 | Serial frame data, MSB first |
| codec_id | input | 2 | Static codec ID; 0 = primary, else secondary with this ID |
| wr_stb | output | 1 | Register write pulse |
| wr_addr | output | 7 | Register write address |
| wr_data | output | 16 | Register write data |
| rd_stb | output | 1 | Register read request pulse |
| rd_addr | output | 7 | Register read address |
| left_stb | output | 1 | Left sample pulse |
| left_pcm | output | 18 | Left sample, top 18 bits of slot 3 |
| right_stb | output | 1 | Right sample pulse |
| right_pcm | output | 18 | Right sample, top 18 bits of slot 4 |

## Verification
The hardest case to reach from the ports is framing that restarts in the middle of a frame. The tracker must drop a half-received frame and count again from bit 0, and no strobe may leak from the abandoned frame. The bench reaches this by cutting a frame off after its tag and the start of slot 1, then starting a complete frame at once. The strobes must appear at bit positions 35, 55, 75 and 95 of the new frame. A second hard case is `sync` held high across two back-to-back frames. The bench drives this and expects the second frame to be ignored.

// File: rtl/codec_frame_pkg.sv
package codec_frame_pkg;
  parameter int TAG_W      = 16;
  parameter int SLOT_W     = 20;
  parameter int FRAME_BITS = 256;
  parameter int ADDR_W     = 7;
  parameter int DATA_W     = 16;
  parameter int DAC_W      = 18;
  parameter int ID_W       = 2;
  parameter int N_EVT      = 5;

  localparam int POS_W  = $clog2(FRAME_BITS);
  localparam int HEAD_W = ADDR_W + 1;
  localparam int FLAG_W = 5;

  typedef struct packed {
    logic frame;
    logic addr_ok;
    logic data_ok;
    logic left_ok;
    logic right_ok;
  } tag_flags_t;

  // frame bit index of the last bit of slot k (slot 0 is the tag)
  function automatic int unsigned slot_last(int unsigned k);
    return TAG_W + k * SLOT_W - 1;
  endfunction

  // helpers on the upper DAC_W bits of a completed slot word
  function automatic logic hi_is_read(logic [DAC_W-1:0] w);
    return w[DAC_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(logic [DAC_W-1:0] w);
    return w[DAC_W-2 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] hi_data(logic [DAC_W-1:0] w);
    return w[DAC_W-1 -: DATA_W];
  endfunction

  // command qualification: flags in primary mode, ID match in secondary
  function automatic logic cmd_qualified(tag_flags_t f, logic [ID_W-1:0] tid,
                                         logic [ID_W-1:0] mine, logic need_data);
    if (mine == '0)
      return f.frame & f.addr_ok & (f.data_ok | ~need_data) & (tid == '0);
    else
      return f.frame & (tid == mine);
  endfunction
endpackage

// File: rtl/frame_tracker.sv
module frame_tracker
  import codec_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  output logic [N_EVT-1:0] slot_end
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic             sync_q;
  logic             running;
  logic [POS_W-1:0] pos_q;
  logic             start;
  logic             bit_valid;
  logic [POS_W-1:0] bit_pos;

  assign start     = sync & ~sync_q;
  assign bit_valid = start | (running & (pos_q != LAST_POS));
  assign bit_pos   = start ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      running <= 1'b0;
      pos_q   <= '0;
    end else begin
      sync_q <= sync;
      if (bit_valid) begin
        running <= 1'b1;
        pos_q   <= bit_pos;
      end else begin
        running <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    assign slot_end[k] = bit_valid && (bit_pos == POS_W'(slot_last(k)));
  end

  // R1: events only occur at distinct positions of a live frame
  p_evt_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_end));
  p_evt_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end != '0) |-> (start || running));
endmodule

// File: rtl/slot_capture.sv
module slot_capture
  import codec_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             tag_end,
  input  logic             s1_end,
  output tag_flags_t       flags,
  output logic [ID_W-1:0]  tag_id,
  output logic [HEAD_W-1:0] head,
  output logic [DAC_W-1:0] word_hi
);
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] word_now;

  // word ending on the current sample, MSB first
  assign word_now = {sh_q, sdata};
  assign word_hi  = word_now[SLOT_W-1 -: DAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      flags  <= '0;
      tag_id <= '0;
      head   <= '0;
    end else begin
      sh_q <= word_now[SLOT_W-2:0];
      if (tag_end) begin
        flags  <= tag_flags_t'(word_now[TAG_W-1 -: FLAG_W]);
        tag_id <= word_now[ID_W-1:0];
      end
      if (s1_end) head <= word_now[SLOT_W-1 -: HEAD_W];
    end
  end

  // tag and head change only at their own slot boundaries
  p_tag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tag_end) |-> $stable(flags) && $stable(tag_id));
  p_head_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(s1_end) |-> $stable(head));
endmodule

// File: rtl/frame_decode.sv
module frame_decode
  import codec_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_end,
  input  logic              s2_end,
  input  logic              s3_end,
  input  logic              s4_end,
  input  tag_flags_t        flags,
  input  logic [ID_W-1:0]   tag_id,
  input  logic [HEAD_W-1:0] head,
  input  logic [DAC_W-1:0]  word_hi,
  input  logic [ID_W-1:0]   codec_id,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              left_stb,
  output logic [DAC_W-1:0]  left_pcm,
  output logic              right_stb,
  output logic [DAC_W-1:0]  right_pcm
);
  logic rd_go, wr_go, left_go, right_go;

  always_comb begin
    rd_go    = s1_end & hi_is_read(word_hi) & cmd_qualified(flags, tag_id, codec_id, 1'b0);
    wr_go    = s2_end & ~head[HEAD_W-1] & cmd_qualified(flags, tag_id, codec_id, 1'b1);
    left_go  = s3_end & flags.frame & flags.left_ok;
    right_go = s4_end & flags.frame & flags.right_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_addr   <= '0;
      left_pcm  <= '0;
      right_pcm <= '0;
    end else begin
      wr_stb    <= wr_go;
      rd_stb    <= rd_go;
      left_stb  <= left_go;
      right_stb <= right_go;
      if (rd_go) rd_addr <= hi_addr(word_hi);
      if (wr_go) begin
        wr_addr <= head[ADDR_W-1:0];
        wr_data <= hi_data(word_hi);
      end
      if (left_go)  left_pcm  <= word_hi;
      if (right_go) right_pcm <= word_hi;
    end
  end

  p_wr_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(s2_end));
  p_rd_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(s1_end));
  p_left_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    left_stb |-> $past(s3_end));
  p_right_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    right_stb |-> $past(s4_end));
  p_id_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && codec_id != '0) |-> (tag_id == codec_id));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb || left_stb || right_stb) |=>
      !(wr_stb || rd_stb || left_stb || right_stb));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(wr_addr) && $stable(wr_data));
endmodule

// File: rtl/codec_frame_rx.sv
module codec_frame_rx
  import codec_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              sdata,
  input  logic [ID_W-1:0]   codec_id,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              left_stb,
  output logic [DAC_W-1:0]  left_pcm,
  output logic              right_stb,
  output logic [DAC_W-1:0]  right_pcm
);
  logic [N_EVT-1:0]  slot_end;
  tag_flags_t        flags;
  logic [ID_W-1:0]   tag_id;
  logic [HEAD_W-1:0] head;
  logic [DAC_W-1:0]  word_hi;

  frame_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (sync),
    .slot_end (slot_end)
  );

  slot_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata   (sdata),
    .tag_end (slot_end[0]),
    .s1_end  (slot_end[1]),
    .flags   (flags),
    .tag_id  (tag_id),
    .head    (head),
    .word_hi (word_hi)
  );

  frame_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_end    (slot_end[1]),
    .s2_end    (slot_end[2]),
    .s3_end    (slot_end[3]),
    .s4_end    (slot_end[4]),
    .flags     (flags),
    .tag_id    (tag_id),
    .head      (head),
    .word_hi   (word_hi),
    .codec_id  (codec_id),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .left_stb  (left_stb),
    .left_pcm  (left_pcm),
    .right_stb (right_stb),
    .right_pcm (right_pcm)
  );
endmodule

// File: tb/sim_codec_frame_rx.sv
`timescale 1ns/1ps
module sim_codec_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  codec_id = 2'd0;
  logic        wr_stb, rd_stb, left_stb, right_stb;
  logic [6:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [17:0] left_pcm, right_pcm;

  always #2.5 clk = ~clk;

  codec_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .sync(sync), .sdata(sdata), .codec_id(codec_id),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr),
    .left_stb(left_stb), .left_pcm(left_pcm),
    .right_stb(right_stb), .right_pcm(right_pcm)
  );

  typedef struct packed {
    logic [1:0]  cid;
    logic [15:0] tag;
    logic [19:0] s1;
    logic [19:0] s2;
    logic [19:0] s3;
    logic [19:0] s4;
    logic        e_wr;
    logic        e_rd;
    logic        e_l;
    logic        e_r;
  } vec_t;

  // cid, tag, slot1..slot4, expect write/read/left/right
  localparam vec_t VECS [9] = '{
    '{2'd0, 16'hF800, 20'h2A000, 20'hBEEF0, 20'h12345, 20'hFEDCB, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 R7 R8
    '{2'd0, 16'hC000, 20'h93000, 20'h00000, 20'h55555, 20'hAAAAA, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    '{2'd0, 16'hD000, 20'h2A000, 20'h12340, 20'h0000F, 20'h11111, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{2'd0, 16'h7800, 20'h11000, 20'h55550, 20'h22222, 20'h33333, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{2'd0, 16'hF801, 20'h11000, 20'h55550, 20'hABCDE, 20'h98765, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 R7
    '{2'd2, 16'h8002, 20'h55000, 20'hCAFE0, 20'h00000, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{2'd2, 16'hE001, 20'h66000, 20'h12120, 20'h00000, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd3, 16'h9803, 20'hFF000, 20'h00000, 20'hFFFFF, 20'h00004, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 R7
    '{2'd1, 16'h8801, 20'h80000, 20'h00000, 20'h13579, 20'h2468C, 1'b0, 1'b1, 1'b0, 1'b1}  // R5 R8
  };

  int n_checks = 0;
  int n_fail = 0;
  int cur_bit = -1;
  int n_wr, n_rd, n_l, n_r;
  int at_wr, at_rd, at_l, at_r;
  logic [6:0]  ex_wa = '0, ex_ra = '0;
  logic [15:0] ex_wd = '0;
  logic [17:0] ex_l = '0, ex_r = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (wr_stb)    begin n_wr++; at_wr = cur_bit; end
    if (rd_stb)    begin n_rd++; at_rd = cur_bit; end
    if (left_stb)  begin n_l++;  at_l  = cur_bit; end
    if (right_stb) begin n_r++;  at_r  = cur_bit; end
  end

  task automatic clear_counts();
    n_wr = 0; n_rd = 0; n_l = 0; n_r = 0;
    at_wr = -1; at_rd = -1; at_l = -1; at_r = -1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync = 1'b0; sdata = 1'b0; cur_bit = -1;
    end
  endtask

  task automatic send(input logic [255:0] frm, input int nbits, input bit hold);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sync = hold ? 1'b1 : (i < 16);
      sdata = frm[255-i];
      cur_bit = i;
    end
  endtask

  function automatic logic [255:0] mk(input vec_t v);
    return {v.tag, v.s1, v.s2, v.s3, v.s4, 160'd0};
  endfunction

  task automatic check_frame(input vec_t v, input string tagname);
    chk(n_wr == int'(v.e_wr), v.cid == 0 ? "R2" : "R5", {tagname, " write count"}, n_wr, v.e_wr);
    chk(n_rd == int'(v.e_rd), v.cid == 0 ? "R3" : "R6", {tagname, " read count"}, n_rd, v.e_rd);
    chk(n_l == int'(v.e_l), "R7", {tagname, " left count"}, n_l, v.e_l);
    chk(n_r == int'(v.e_r), "R8", {tagname, " right count"}, n_r, v.e_r);
    if (v.e_wr) begin
      ex_wa = 7'((v.s1 >> 12) % 128);
      ex_wd = 16'(v.s2 >> 4);
      chk(at_wr == 55, "R2", {tagname, " write timing"}, at_wr, 55);
    end
    if (v.e_rd) begin
      ex_ra = 7'((v.s1 >> 12) % 128);
      chk(at_rd == 35, "R3", {tagname, " read timing"}, at_rd, 35);
    end
    if (v.e_l) begin
      ex_l = 18'(v.s3 >> 2);
      chk(at_l == 75, "R7", {tagname, " left timing"}, at_l, 75);
    end
    if (v.e_r) begin
      ex_r = 18'(v.s4 >> 2);
      chk(at_r == 95, "R8", {tagname, " right timing"}, at_r, 95);
    end
    // values: fresh on a strobe, otherwise held (R9)
    chk(wr_addr == ex_wa, "R9", {tagname, " wr_addr"}, wr_addr, ex_wa);
    chk(wr_data == ex_wd, "R9", {tagname, " wr_data"}, wr_data, ex_wd);
    chk(rd_addr == ex_ra, "R9", {tagname, " rd_addr"}, rd_addr, ex_ra);
    chk(left_pcm == ex_l, "R9", {tagname, " left_pcm"}, left_pcm, ex_l);
    chk(right_pcm == ex_r, "R9", {tagname, " right_pcm"}, right_pcm, ex_r);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_counts();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({wr_stb, rd_stb, left_stb, right_stb} == 4'b0, "R9", "reset strobes",
        {wr_stb, rd_stb, left_stb, right_stb}, 0);
    chk({wr_addr, wr_data, rd_addr, left_pcm, right_pcm} == '0, "R9", "reset buses",
        {wr_addr, wr_data}, 0);
    rst_n = 1'b1;
    idle(4);

    // R10: junk with sync low before any frame
    clear_counts();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      sdata = 1'($urandom);
    end
    idle(4);
    chk(n_wr + n_rd + n_l + n_r == 0, "R10", "strobes before frame", n_wr + n_rd + n_l + n_r, 0);

    // table of frames
    for (int k = 0; k < 9; k++) begin
      codec_id = VECS[k].cid;
      idle(4);
      clear_counts();
      send(mk(VECS[k]), 256, 1'b0);
      idle(4);
      check_frame(VECS[k], $sformatf("vec%0d", k));
    end

    // R1: restart mid-frame; abandoned partial frame yields nothing
    codec_id = 2'd0;
    idle(4);
    clear_counts();
    send(mk(VECS[1]), 30, 1'b0);
    chk(n_wr + n_rd + n_l + n_r == 0, "R1", "partial frame strobes", n_wr + n_rd + n_l + n_r, 0);
    send(mk(VECS[0]), 256, 1'b0);
    idle(4);
    check_frame(VECS[0], "R1 resync");

    // R1: sync held high across two frames; second is not a frame start
    idle(4);
    clear_counts();
    send(mk(VECS[0]), 256, 1'b1);
    check_frame(VECS[0], "R1 hold first");
    clear_counts();
    send(mk(VECS[7]), 256, 1'b1);
    idle(4);
    chk(n_wr + n_rd + n_l + n_r == 0, "R1", "held sync second frame", n_wr + n_rd + n_l + n_r, 0);

    // R10: bits after frame end without a new start
    clear_counts();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sync = 1'b0;
      sdata = 1'b1;
    end
    idle(2);
    chk(n_wr + n_rd + n_l + n_r == 0, "R10", "after frame end", n_wr + n_rd + n_l + n_r, 0);
    chk(left_pcm == ex_l, "R9", "left hold after idle", left_pcm, ex_l);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule